// File: doc/BRIEF.md
# Status Flag and Condition Unit

This block holds the four arithmetic condition flags of a 32-bit RISC datapath, plus a sticky saturation flag. On each operation it takes a class code, the result word computed elsewhere, the carry and overflow bits from the external adder, and the carry bit from the external shifter. It then decides whether the flags change and what their new values are. Compare and test operations always update the flags. The other classes update them only when the instruction asks for it.

The same block also evaluates a 4-bit condition code against the flags currently held, and gives a registered pass/fail bit. The issue logic uses that bit to squash or commit the instruction. An explicit status write loads all five flags at once. It is the only way to clear the sticky flag.

Top module: `flag_cond_unit`

## Requirements
- R1: While `rst` is high, and at the first edge that sees it, `status_word` becomes all zeros and `cond_pass` becomes 0.
- R2: Flags change on an operation only when `op_valid` is 1 and either `set_flags` is 1 or the class is compare (2), test-AND (4) or test-XOR (5). The class codes are add=0, sub=1, compare=2, logical=3, test-AND=4, test-XOR=5, move=6, and 7 is reserved and never changes N, Z, C or V.
- R3: On an updating operation, N (bit 31) takes `result[31]`, and Z (bit 30) is 1 exactly when `result` is zero.
- R4: On an updating add, C (bit 29) takes `add_cout` and V (bit 28) takes `add_ovf`.
- R5: On an updating sub or compare, `add_cout` reports a borrow (1 = borrow). C becomes its inverse and V takes `add_ovf`.
- R6: On an updating logical, test-AND, test-XOR or move, C takes `shf_cout` when `shf_used` is 1 and otherwise keeps its value. V always keeps its value.
- R7: Q (bit 27) is set when `op_valid` and `sat_hit` are both 1, whatever the class or `set_flags`. Once set, it stays set until a status write.
- R8: When `stat_wr` is 1, bits 31..27 of `stat_wr_data` load N, Z, C, V and Q. This takes priority over any operation in the same cycle.
- R9: `cond_pass` is registered. One edge after a code is presented, it shows the result for that code against the flags held before that edge. The codes are: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V); 14 and 15 always.
- R10: Bits 26..0 of `status_word` always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation completes this cycle |
| op_class | input | 3 | Operation class code |
| set_flags | input | 1 | Instruction requests a flag update |
| result | input | 32 | Result word (AND/XOR value for tests) |
| add_cout | input | 1 | Adder carry-out (borrow on subtract) |
| add_ovf | input | 1 | Adder signed overflow |
| shf_used | input | 1 | Operand went through the shifter |
| shf_cout | input | 1 | Last bit shifted out |
| sat_hit | input | 1 | Saturating operation clipped |
| stat_wr | input | 1 | Explicit status write |
| stat_wr_data | input | 32 | Status write value (bits 31..27 used) |
| cond_code | input | 4 | Condition code to evaluate |
| status_word | output | 32 | Held status word |
| cond_pass | output | 1 | Registered condition result |

## Verification
The flags in `status_word` follow an operation one edge after it is presented. The bench drives each stimulus at the falling edge and compares shortly after the next rising edge. `cond_pass` is also due at that edge, but it is checked against the bench's model flags from before the edge. This catches a design that evaluates the code on the new flags. Directed steps load chosen flag patterns by status write and then walk all sixteen codes. Each code's expected value is taken from the model flags one cycle earlier.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_CMP   = 3'd2,
    OP_LOGIC = 3'd3,
    OP_TST   = 3'd4,
    OP_TEQ   = 3'd5,
    OP_MOV   = 3'd6,
    OP_RSVD  = 3'd7
  } op_class_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
    logic q;
  } flags_t;

  localparam int FLAG_CNT = 5;
endpackage

// File: rtl/fcu_flag_next.sv
module fcu_flag_next
  import fcu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  flags_t              cur,
  input  logic                op_valid,
  input  logic [2:0]          op_class,
  input  logic                set_flags,
  input  logic [DATA_W-1:0]   result,
  input  logic                add_cout,
  input  logic                add_ovf,
  input  logic                shf_used,
  input  logic                shf_cout,
  input  logic                sat_hit,
  output flags_t              nxt
);
  op_class_e cls;
  logic      forced;
  logic      apply;

  always_comb begin
    cls    = op_class_e'(op_class);
    forced = (cls == OP_CMP) || (cls == OP_TST) || (cls == OP_TEQ);
    apply  = op_valid && (set_flags || forced) && (cls != OP_RSVD);
    nxt    = cur;
    if (apply) begin
      nxt.n = result[DATA_W-1];
      nxt.z = (result == '0);
      unique case (cls)
        OP_ADD: begin
          nxt.c = add_cout;
          nxt.v = add_ovf;
        end
        OP_SUB, OP_CMP: begin
          nxt.c = ~add_cout;
          nxt.v = add_ovf;
        end
        default: begin
          if (shf_used) nxt.c = shf_cout;
        end
      endcase
    end
    if (op_valid && sat_hit) nxt.q = 1'b1;
  end
endmodule

// File: rtl/fcu_status_reg.sv
module fcu_status_reg
  import fcu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wr_en,
  input  flags_t wr_flags,
  input  flags_t nxt,
  output flags_t cur
);
  always_ff @(posedge clk) begin
    if (rst)        cur <= '0;
    else if (wr_en) cur <= wr_flags;
    else            cur <= nxt;
  end
endmodule

// File: rtl/fcu_cond_eval.sv
module fcu_cond_eval
  import fcu_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  flags_t            flg,
  input  logic [CODE_W-1:0] code,
  output logic              pass
);
  logic nv_eq;

  always_comb begin
    nv_eq = (flg.n == flg.v);
    unique case (code)
      4'd0:    pass = flg.z;
      4'd1:    pass = ~flg.z;
      4'd2:    pass = flg.c;
      4'd3:    pass = ~flg.c;
      4'd4:    pass = flg.n;
      4'd5:    pass = ~flg.n;
      4'd6:    pass = flg.v;
      4'd7:    pass = ~flg.v;
      4'd8:    pass = flg.c & ~flg.z;
      4'd9:    pass = ~flg.c | flg.z;
      4'd10:   pass = nv_eq;
      4'd11:   pass = ~nv_eq;
      4'd12:   pass = ~flg.z & nv_eq;
      4'd13:   pass = flg.z | ~nv_eq;
      default: pass = 1'b1;
    endcase
  end
endmodule

// File: rtl/flag_cond_unit.sv
module flag_cond_unit
  import fcu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_class,
  input  logic              set_flags,
  input  logic [DATA_W-1:0] result,
  input  logic              add_cout,
  input  logic              add_ovf,
  input  logic              shf_used,
  input  logic              shf_cout,
  input  logic              sat_hit,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] stat_wr_data,
  input  logic [CODE_W-1:0] cond_code,
  output logic [DATA_W-1:0] status_word,
  output logic              cond_pass
);
  localparam int FLAG_LO = DATA_W - FLAG_CNT;

  flags_t cur_flags;
  flags_t nxt_flags;
  flags_t wr_flags;
  logic   pass_c;

  assign wr_flags = flags_t'(stat_wr_data[DATA_W-1:FLAG_LO]);

  fcu_flag_next #(.DATA_W(DATA_W)) next_i (
    .cur(cur_flags), .op_valid(op_valid), .op_class(op_class),
    .set_flags(set_flags), .result(result), .add_cout(add_cout),
    .add_ovf(add_ovf), .shf_used(shf_used), .shf_cout(shf_cout),
    .sat_hit(sat_hit), .nxt(nxt_flags)
  );

  fcu_status_reg reg_i (
    .clk(clk), .rst(rst), .wr_en(stat_wr), .wr_flags(wr_flags),
    .nxt(nxt_flags), .cur(cur_flags)
  );

  fcu_cond_eval #(.CODE_W(CODE_W)) eval_i (
    .flg(cur_flags), .code(cond_code), .pass(pass_c)
  );

  always_ff @(posedge clk) begin
    if (rst) cond_pass <= 1'b0;
    else     cond_pass <= pass_c;
  end

  assign status_word = {cur_flags, {FLAG_LO{1'b0}}};
endmodule

// File: rtl/fcu_checker.sv
module fcu_checker #(
  parameter int DATA_W = 32,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [2:0]        op_class,
  input logic              set_flags,
  input logic [DATA_W-1:0] result,
  input logic              stat_wr,
  input logic [DATA_W-1:0] stat_wr_data,
  input logic [CODE_W-1:0] cond_code,
  input logic [DATA_W-1:0] status_word,
  input logic              cond_pass
);
  logic opt_class;
  logic upd_class;
  assign opt_class = (op_class == 3'd0) || (op_class == 3'd1) ||
                     (op_class == 3'd3) || (op_class == 3'd6);
  assign upd_class = (op_class != 3'd7);

  assert_no_update_R2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !set_flags && opt_class && !stat_wr)
      |=> $stable(status_word[DATA_W-1:DATA_W-4]));

  assert_zero_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && set_flags && upd_class && !stat_wr)
      |=> (status_word[DATA_W-2] == ($past(result) == '0)));

  assert_q_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (status_word[DATA_W-5] && !stat_wr) |=> status_word[DATA_W-5]);

  assert_wr_load_R8: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> (status_word[DATA_W-1:DATA_W-5] == $past(stat_wr_data[DATA_W-1:DATA_W-5])));

  assert_always_code_R9: assert property (@(posedge clk) disable iff (rst)
    (cond_code == 4'd14) |=> cond_pass);

  assert_low_zero_R10: assert property (@(posedge clk) disable iff (rst)
    status_word[DATA_W-6:0] == '0);
endmodule

bind flag_cond_unit fcu_checker #(.DATA_W(DATA_W), .CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_class(op_class),
  .set_flags(set_flags), .result(result), .stat_wr(stat_wr),
  .stat_wr_data(stat_wr_data), .cond_code(cond_code),
  .status_word(status_word), .cond_pass(cond_pass)
);

// File: tb/flag_cond_unit_tb_top.sv
module flag_cond_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid, set_flags, add_cout, add_ovf, shf_used, shf_cout, sat_hit, stat_wr;
  logic [2:0]  op_class;
  logic [31:0] result, stat_wr_data, status_word;
  logic [3:0]  cond_code;
  logic        cond_pass;

  int total = 0;
  int bad   = 0;
  logic [4:0] mf;

  always #2 clk = ~clk;

  flag_cond_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_class(op_class),
    .set_flags(set_flags), .result(result), .add_cout(add_cout),
    .add_ovf(add_ovf), .shf_used(shf_used), .shf_cout(shf_cout),
    .sat_hit(sat_hit), .stat_wr(stat_wr), .stat_wr_data(stat_wr_data),
    .cond_code(cond_code), .status_word(status_word), .cond_pass(cond_pass)
  );

  function automatic logic exp_cond(logic [4:0] f, logic [3:0] c);
    logic n, z, cy, v;
    n = f[4]; z = f[3]; cy = f[2]; v = f[1];
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [4:0] exp_next(logic [4:0] f);
    logic [4:0] r;
    logic upd;
    r = f;
    upd = op_valid && (op_class != 3'd7) &&
          (set_flags || op_class == 3'd2 || op_class == 3'd4 || op_class == 3'd5);
    if (upd) begin
      r[4] = result[31];
      r[3] = (result == 32'd0);
      if (op_class == 3'd0) begin r[2] = add_cout; r[1] = add_ovf; end
      else if (op_class == 3'd1 || op_class == 3'd2) begin r[2] = !add_cout; r[1] = add_ovf; end
      else if (shf_used) r[2] = shf_cout;
    end
    if (op_valid && sat_hit) r[0] = 1'b1;
    if (stat_wr) r = stat_wr_data[31:27];
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    op_valid = 0; op_class = 3'd0; set_flags = 0; result = 32'd1;
    add_cout = 0; add_ovf = 0; shf_used = 0; shf_cout = 0; sat_hit = 0;
    stat_wr = 0; stat_wr_data = 32'd0; cond_code = 4'd14;
  endtask

  task automatic step(string tag);
    logic [4:0] nf;
    logic       ep;
    nf = exp_next(mf);
    ep = exp_cond(mf, cond_code);
    @(posedge clk);
    #1;
    check(tag, status_word, {nf, 27'd0});
    check("R9", {31'd0, cond_pass}, {31'd0, ep});
    mf = nf;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wr_flags(logic [4:0] f);
    stat_wr = 1; stat_wr_data = {f, 27'h5a5a5a5};
    step("R8");
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle_inputs();
    rst = 1;
    mf = 5'd0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", status_word, 32'd0);
    check("R1", {31'd0, cond_pass}, 32'd0);
    @(negedge clk);
    rst = 0;

    // R3: zero result sets Z, negative sets N
    op_valid = 1; op_class = 3'd6; set_flags = 1; result = 32'd0; step("R3");
    op_valid = 1; op_class = 3'd3; set_flags = 1; result = 32'h8000_0000; step("R3");
    // R4 add carry/overflow
    op_valid = 1; op_class = 3'd0; set_flags = 1; add_cout = 1; add_ovf = 1; step("R4");
    // R5 compare with borrow clears C, without borrow sets it
    op_valid = 1; op_class = 3'd2; add_cout = 1; step("R5");
    op_valid = 1; op_class = 3'd1; set_flags = 1; add_cout = 0; step("R5");
    // R6 logical without shifter keeps C; with shifter takes shf_cout; V kept
    wr_flags(5'b00110);
    op_valid = 1; op_class = 3'd4; shf_used = 0; shf_cout = 0; result = 32'd3; step("R6");
    op_valid = 1; op_class = 3'd5; shf_used = 1; shf_cout = 0; result = 32'd0; step("R6");
    // R2 no set_flags on add leaves flags; reserved class never changes NZCV
    op_valid = 1; op_class = 3'd0; set_flags = 0; result = 32'd0; add_cout = 1; step("R2");
    op_valid = 1; op_class = 3'd7; set_flags = 1; result = 32'd0; step("R2");
    // R7 Q sticky, cleared only by write
    op_valid = 1; op_class = 3'd0; set_flags = 0; sat_hit = 1; step("R7");
    op_valid = 1; op_class = 3'd3; set_flags = 1; result = 32'd9; step("R7");
    check("R7", {31'd0, status_word[27]}, 32'd1);
    wr_flags(5'b00000);
    // R8 write wins over a same-cycle op
    op_valid = 1; op_class = 3'd2; result = 32'd0; stat_wr = 1; stat_wr_data = 32'hA800_0000; step("R8");
    // R9 all codes over several flag patterns
    for (int p = 0; p < 16; p++) begin
      wr_flags({p[3:0], 1'b0});
      for (int c = 0; c < 16; c++) begin
        cond_code = c[3:0];
        step("R9");
      end
    end
    // random mix
    for (int i = 0; i < 3000; i++) begin
      op_valid  = ($urandom % 8) != 0;
      op_class  = 3'($urandom % 8);
      set_flags = $urandom % 2;
      result    = (($urandom % 6) == 0) ? 32'd0 : $urandom;
      add_cout  = $urandom % 2;
      add_ovf   = $urandom % 2;
      shf_used  = $urandom % 2;
      shf_cout  = $urandom % 2;
      sat_hit   = ($urandom % 12) == 0;
      stat_wr   = ($urandom % 16) == 0;
      stat_wr_data = $urandom;
      cond_code = 4'($urandom % 16);
      if (stat_wr) step("R8");
      else if (op_class == 3'd0) step("R4");
      else if (op_class == 3'd1 || op_class == 3'd2) step("R5");
      else if (op_class == 3'd7) step("R2");
      else step("R6");
      check("R10", {5'd0, status_word[26:0]}, 32'd0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule